// File: doc/BRIEF.md
# Shifter-ALU Compound Functional Unit

This block is a 32-bit word processing element for a statically scheduled compute fabric. An arithmetic/logic unit, a predicate-steered select and a logarithmic funnel shifter sit behind one shared pair of operand ports and one result port. They are treated as a single device. A 4-bit configuration opcode arrives every cycle, and exactly one operation completes per issue.

Comparisons produce a 1-bit flag for the control path and write zero to the word result. The select operation takes a 1-bit predicate from the control path and returns one operand or the other. Shift distances come from a 5-bit immediate in the configuration word. Both outputs are registered, so every result appears one clock after it is issued, together with a valid bit.

Top module: `shalu_unit`

## Requirements
- R1: While `rst` is high, the next clock edge clears `res_o`, `flag_o` and `vld_o` to zero.
- R2: An operation issued at a clock edge appears on the outputs at that edge and not before it. `vld_o` is 1 for every opcode in the range 1 to 14.
- R3: Opcode 1 gives A+B, opcode 2 gives A-B and opcode 3 gives 0-A. All three wrap modulo 2^32.
- R4: Opcode 4 gives A AND B, opcode 5 gives A OR B and opcode 6 gives A XOR B.
- R5: Opcode 7 (select) gives A when `pred_i` is 1 and B when `pred_i` is 0.
- R6: Opcode 8 tests A==B, opcode 9 tests signed A<B and opcode 10 tests unsigned A<B. For all three, `flag_o` is the test outcome and `res_o` is zero.
- R7: For every opcode other than 8, 9 and 10, `flag_o` is 0, whatever the value of `pred_i`.
- R8: Opcode 11 shifts A left logically, opcode 12 shifts A right logically and opcode 13 shifts A right arithmetically, each by `shamt_i`. A distance of zero returns A unchanged.
- R9: Opcode 14 (funnel) returns bits 31..0 of the 64-bit word {A,B} shifted right by `shamt_i`. A distance of zero returns B.
- R10: Opcode 0 (no operation) and the unused opcode 15 give `vld_o`=0, `res_o`=0 and `flag_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Configuration opcode for this cycle |
| shamt_i | input | 5 | Shift distance immediate |
| pred_i | input | 1 | Control-path predicate used by select |
| a_i | input | 32 | Operand A (also the high funnel word) |
| b_i | input | 32 | Operand B (also the low funnel word) |
| res_o | output | 32 | Registered word result |
| flag_o | output | 1 | Registered comparison outcome |
| vld_o | output | 1 | Registered valid bit for the issued operation |

## Verification
The cases that are hardest to reach from the ports are the shifter corners, since every funnel stage must be exercised:
- a distance of 31, where the top bits of B must cross into the result;
- an arithmetic shift of a negative word by 31;
- a left shift that travels through the bit-reversal path.

The vector table drives these distances on purpose, with operands chosen so that each stage leaves a distinct mark on the result. Operand pairs where signed and unsigned ordering disagree separate the two less-than tests. Negating the most negative word checks the wrap case.

A select issued with the predicate high, followed by an add with the predicate still high, shows that the predicate never leaks into `flag_o`.

// File: rtl/shalu_pkg.sv
package shalu_pkg;

    localparam int unsigned FU_W   = 32;
    localparam int unsigned FU_SHW = $clog2(FU_W);
    localparam int unsigned OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_NEG  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_SEL  = 4'd7,
        OP_EQ   = 4'd8,
        OP_LT   = 4'd9,
        OP_LTU  = 4'd10,
        OP_SLL  = 4'd11,
        OP_SRL  = 4'd12,
        OP_SRA  = 4'd13,
        OP_FSR  = 4'd14
    } op_e;

    typedef enum logic [2:0] {
        U_NONE  = 3'd0,
        U_ARITH = 3'd1,
        U_LOGIC = 3'd2,
        U_CMP   = 3'd3,
        U_SEL   = 3'd4,
        U_SHIFT = 3'd5
    } unit_e;

    // Function codes inside each unit
    localparam logic [1:0] FN_ADD = 2'd0;
    localparam logic [1:0] FN_SUB = 2'd1;
    localparam logic [1:0] FN_NEG = 2'd2;

    localparam logic [1:0] FN_AND = 2'd0;
    localparam logic [1:0] FN_OR  = 2'd1;
    localparam logic [1:0] FN_XOR = 2'd2;

    localparam logic [1:0] FN_EQ  = 2'd0;
    localparam logic [1:0] FN_LT  = 2'd1;
    localparam logic [1:0] FN_LTU = 2'd2;

    localparam logic [1:0] FN_SLL = 2'd0;
    localparam logic [1:0] FN_SRL = 2'd1;
    localparam logic [1:0] FN_SRA = 2'd2;
    localparam logic [1:0] FN_FSR = 2'd3;

    typedef struct packed {
        logic       vld;
        unit_e      unit;
        logic [1:0] fn;
    } dec_t;

    function automatic logic is_cmp(input logic [OP_W-1:0] op);
        return (op == OP_EQ) || (op == OP_LT) || (op == OP_LTU);
    endfunction

    function automatic logic is_issue(input logic [OP_W-1:0] op);
        return (op != OP_NOP) && (op != 4'd15);
    endfunction

endpackage

// File: rtl/shalu_decode.sv
module shalu_decode
    import shalu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output dec_t            dec_o
);

    always_comb begin
        dec_o = '{vld: 1'b0, unit: U_NONE, fn: 2'd0};
        case (op_i)
            OP_ADD: dec_o = '{vld: 1'b1, unit: U_ARITH, fn: FN_ADD};
            OP_SUB: dec_o = '{vld: 1'b1, unit: U_ARITH, fn: FN_SUB};
            OP_NEG: dec_o = '{vld: 1'b1, unit: U_ARITH, fn: FN_NEG};
            OP_AND: dec_o = '{vld: 1'b1, unit: U_LOGIC, fn: FN_AND};
            OP_OR:  dec_o = '{vld: 1'b1, unit: U_LOGIC, fn: FN_OR};
            OP_XOR: dec_o = '{vld: 1'b1, unit: U_LOGIC, fn: FN_XOR};
            OP_SEL: dec_o = '{vld: 1'b1, unit: U_SEL,   fn: 2'd0};
            OP_EQ:  dec_o = '{vld: 1'b1, unit: U_CMP,   fn: FN_EQ};
            OP_LT:  dec_o = '{vld: 1'b1, unit: U_CMP,   fn: FN_LT};
            OP_LTU: dec_o = '{vld: 1'b1, unit: U_CMP,   fn: FN_LTU};
            OP_SLL: dec_o = '{vld: 1'b1, unit: U_SHIFT, fn: FN_SLL};
            OP_SRL: dec_o = '{vld: 1'b1, unit: U_SHIFT, fn: FN_SRL};
            OP_SRA: dec_o = '{vld: 1'b1, unit: U_SHIFT, fn: FN_SRA};
            OP_FSR: dec_o = '{vld: 1'b1, unit: U_SHIFT, fn: FN_FSR};
            default: dec_o = '{vld: 1'b0, unit: U_NONE, fn: 2'd0};
        endcase
    end

endmodule

// File: rtl/shalu_alu.sv
module shalu_alu
    import shalu_pkg::*;
#(
    parameter int unsigned DATA_W = FU_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              pred_i,
    input  unit_e             unit_i,
    input  logic [1:0]        fn_i,
    output logic [DATA_W-1:0] word_o,
    output logic              flag_o
);

    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic [DATA_W-1:0] logic_res;
    logic              cmp_res;

    // One shared adder: subtract and negate use inverted operand plus carry-in
    always_comb begin
        add_x   = a_i;
        add_y   = b_i;
        add_cin = 1'b0;
        case (fn_i)
            FN_SUB: begin
                add_y   = ~b_i;
                add_cin = 1'b1;
            end
            FN_NEG: begin
                add_x   = '0;
                add_y   = ~a_i;
                add_cin = 1'b1;
            end
            default: ;
        endcase
    end

    assign add_sum = add_x + add_y + {{(DATA_W-1){1'b0}}, add_cin};

    always_comb begin
        case (fn_i)
            FN_AND:  logic_res = a_i & b_i;
            FN_OR:   logic_res = a_i | b_i;
            FN_XOR:  logic_res = a_i ^ b_i;
            default: logic_res = '0;
        endcase
    end

    always_comb begin
        case (fn_i)
            FN_EQ:   cmp_res = (a_i == b_i);
            FN_LT:   cmp_res = ($signed(a_i) < $signed(b_i));
            FN_LTU:  cmp_res = (a_i < b_i);
            default: cmp_res = 1'b0;
        endcase
    end

    always_comb begin
        word_o = '0;
        flag_o = 1'b0;
        case (unit_i)
            U_ARITH: word_o = add_sum;
            U_LOGIC: word_o = logic_res;
            U_SEL:   word_o = pred_i ? a_i : b_i;
            U_CMP:   flag_o = cmp_res;
            default: ;
        endcase
    end

endmodule

// File: rtl/shalu_funnel.sv
module shalu_funnel #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SHW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [SHW-1:0]    amt_i,
    output logic [DATA_W-1:0] out_o
);

    localparam int unsigned CAT_W = 2 * DATA_W;

    logic [CAT_W-1:0] stg [0:SHW];

    assign stg[0] = {hi_i, lo_i};

    // Largest stride first: stages of 16, 8, 4, 2, 1 at the default width
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int unsigned K = SHW - 1 - i;
        assign stg[i+1] = amt_i[K] ? (stg[i] >> (2**K)) : stg[i];
    end

    assign out_o = stg[SHW][DATA_W-1:0];

endmodule

// File: rtl/shalu_shift.sv
module shalu_shift
    import shalu_pkg::*;
#(
    parameter int unsigned DATA_W = FU_W,
    parameter int unsigned SHW    = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [SHW-1:0]    amt_i,
    input  logic [1:0]        fn_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] a_rev;
    logic [DATA_W-1:0] f_hi;
    logic [DATA_W-1:0] f_lo;
    logic [DATA_W-1:0] f_out;
    logic [DATA_W-1:0] f_out_rev;

    for (genvar j = 0; j < DATA_W; j++) begin : g_rev
        assign a_rev[j]     = a_i[DATA_W-1-j];
        assign f_out_rev[j] = f_out[DATA_W-1-j];
    end

    // Fill word selection turns the right funnel into every shift flavour
    always_comb begin
        case (fn_i)
            FN_SLL: begin
                f_hi = '0;
                f_lo = a_rev;
            end
            FN_SRL: begin
                f_hi = '0;
                f_lo = a_i;
            end
            FN_SRA: begin
                f_hi = {DATA_W{a_i[DATA_W-1]}};
                f_lo = a_i;
            end
            default: begin
                f_hi = a_i;
                f_lo = b_i;
            end
        endcase
    end

    shalu_funnel #(
        .DATA_W (DATA_W),
        .SHW    (SHW)
    ) u_funnel (
        .hi_i  (f_hi),
        .lo_i  (f_lo),
        .amt_i (amt_i),
        .out_o (f_out)
    );

    assign word_o = (fn_i == FN_SLL) ? f_out_rev : f_out;

endmodule

// File: rtl/shalu_unit.sv
module shalu_unit
    import shalu_pkg::*;
#(
    parameter int unsigned DATA_W = FU_W,
    parameter int unsigned SHW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [SHW-1:0]    shamt_i,
    input  logic              pred_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o,
    output logic              flag_o,
    output logic              vld_o
);

    dec_t              dec;
    logic [DATA_W-1:0] alu_word;
    logic              alu_flag;
    logic [DATA_W-1:0] sh_word;
    logic [DATA_W-1:0] res_n;
    logic              flag_n;

    shalu_decode u_decode (
        .op_i  (op_i),
        .dec_o (dec)
    );

    shalu_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a_i    (a_i),
        .b_i    (b_i),
        .pred_i (pred_i),
        .unit_i (dec.unit),
        .fn_i   (dec.fn),
        .word_o (alu_word),
        .flag_o (alu_flag)
    );

    shalu_shift #(
        .DATA_W (DATA_W),
        .SHW    (SHW)
    ) u_shift (
        .a_i    (a_i),
        .b_i    (b_i),
        .amt_i  (shamt_i),
        .fn_i   (dec.fn),
        .word_o (sh_word)
    );

    // One result port: a single unit drives it per issue
    always_comb begin
        res_n  = '0;
        flag_n = 1'b0;
        if (dec.unit == U_SHIFT) begin
            res_n = sh_word;
        end else if (dec.unit != U_NONE) begin
            res_n  = alu_word;
            flag_n = alu_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o  <= '0;
            flag_o <= 1'b0;
            vld_o  <= 1'b0;
        end else begin
            res_o  <= res_n;
            flag_o <= flag_n;
            vld_o  <= dec.vld;
        end
    end

endmodule

// File: rtl/shalu_chk.sv
module shalu_chk
    import shalu_pkg::*;
#(
    parameter int unsigned DATA_W = FU_W,
    parameter int unsigned SHW    = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_i,
    input logic [SHW-1:0]    shamt_i,
    input logic              pred_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] res_o,
    input logic              flag_o,
    input logic              vld_o
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!vld_o && !flag_o && res_o == '0)); // R1

    AST_ISSUE_VALID: assert property (@(posedge clk) disable iff (rst)
        is_issue(op_i) |=> vld_o); // R2

    AST_SEL_TAKES_A: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SEL && pred_i) |=> (res_o == $past(a_i))); // R5

    AST_SEL_TAKES_B: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SEL && !pred_i) |=> (res_o == $past(b_i))); // R5

    AST_CMP_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        is_cmp(op_i) |=> (res_o == '0)); // R6

    AST_FLAG_CMP_ONLY: assert property (@(posedge clk) disable iff (rst)
        !is_cmp(op_i) |=> !flag_o); // R7

    AST_SHIFT_ZERO_DIST: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_SLL || op_i == OP_SRL || op_i == OP_SRA) && shamt_i == '0)
        |=> (res_o == $past(a_i))); // R8

    AST_FUNNEL_ZERO_DIST: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_FSR && shamt_i == '0) |=> (res_o == $past(b_i))); // R9

    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        !is_issue(op_i) |=> (!vld_o && !flag_o && res_o == '0)); // R10

endmodule

bind shalu_unit shalu_chk #(
    .DATA_W (DATA_W),
    .SHW    (SHW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .shamt_i (shamt_i),
    .pred_i  (pred_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .res_o   (res_o),
    .flag_o  (flag_o),
    .vld_o   (vld_o)
);

// File: tb/shalu_unit_tb.sv
`timescale 1ns/1ps
module shalu_unit_tb;

    typedef struct packed {
        logic [3:0]  op;
        logic [4:0]  sh;
        logic        p;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] eres;
        logic        eflag;
        logic        evld;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  5'd0,  1'b1, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b1}, // R3 R7
        '{4'd1,  5'd0,  1'b0, 32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001, 1'b0, 1'b1}, // R3 wrap
        '{4'd2,  5'd0,  1'b0, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 1'b0, 1'b1}, // R3
        '{4'd3,  5'd0,  1'b0, 32'h0000_0001, 32'h1234_0000, 32'hFFFF_FFFF, 1'b0, 1'b1}, // R3
        '{4'd3,  5'd0,  1'b0, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R3
        '{4'd4,  5'd0,  1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0, 1'b1}, // R4
        '{4'd5,  5'd0,  1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0, 1'b0, 1'b1}, // R4
        '{4'd6,  5'd0,  1'b0, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0, 1'b1}, // R4
        '{4'd7,  5'd0,  1'b1, 32'hAAAA_AAAA, 32'h5555_5555, 32'hAAAA_AAAA, 1'b0, 1'b1}, // R5 R7
        '{4'd7,  5'd0,  1'b0, 32'hAAAA_AAAA, 32'h5555_5555, 32'h5555_5555, 1'b0, 1'b1}, // R5
        '{4'd8,  5'd0,  1'b0, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 1'b1, 1'b1}, // R6
        '{4'd8,  5'd0,  1'b0, 32'h1234_5678, 32'h1234_5679, 32'h0000_0000, 1'b0, 1'b1}, // R6
        '{4'd9,  5'd0,  1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1}, // R6
        '{4'd10, 5'd0,  1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1}, // R6
        '{4'd9,  5'd0,  1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1}, // R6
        '{4'd10, 5'd0,  1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 1'b1}, // R6
        '{4'd11, 5'd4,  1'b0, 32'h8000_0001, 32'h0000_0000, 32'h0000_0010, 1'b0, 1'b1}, // R8
        '{4'd11, 5'd0,  1'b0, 32'h8000_0001, 32'hFFFF_FFFF, 32'h8000_0001, 1'b0, 1'b1}, // R8
        '{4'd11, 5'd31, 1'b0, 32'h0000_0003, 32'h0000_0000, 32'h8000_0000, 1'b0, 1'b1}, // R8
        '{4'd12, 5'd4,  1'b0, 32'h8000_0010, 32'h0000_0000, 32'h0800_0001, 1'b0, 1'b1}, // R8
        '{4'd13, 5'd4,  1'b0, 32'h8000_0010, 32'h0000_0000, 32'hF800_0001, 1'b0, 1'b1}, // R8
        '{4'd13, 5'd31, 1'b0, 32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b1}, // R8
        '{4'd13, 5'd31, 1'b0, 32'h7FFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1}, // R8
        '{4'd14, 5'd8,  1'b0, 32'h1122_3344, 32'h5566_7788, 32'h4455_6677, 1'b0, 1'b1}, // R9
        '{4'd14, 5'd0,  1'b0, 32'h1122_3344, 32'h5566_7788, 32'h5566_7788, 1'b0, 1'b1}, // R9
        '{4'd14, 5'd31, 1'b0, 32'h0000_0001, 32'h8000_0000, 32'h0000_0003, 1'b0, 1'b1}, // R9
        '{4'd14, 5'd21, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_07FF, 1'b0, 1'b1}, // R9
        '{4'd0,  5'd3,  1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0}, // R10
        '{4'd15, 5'd3,  1'b1, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000, 1'b0, 1'b0}, // R10
        '{4'd1,  5'd0,  1'b0, 32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 1'b0, 1'b1}  // R2 after silent op
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = 4'd0;
    logic [4:0]  shamt_i = 5'd0;
    logic        pred_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] res_o;
    logic        flag_o;
    logic        vld_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shalu_unit u_dut (
        .clk     (clk),
        .rst     (rst),
        .op_i    (op_i),
        .shamt_i (shamt_i),
        .pred_i  (pred_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .res_o   (res_o),
        .flag_o  (flag_o),
        .vld_o   (vld_o)
    );

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd1, 4'd2, 4'd3:    return "R3";
            4'd4, 4'd5, 4'd6:    return "R4";
            4'd7:                return "R5";
            4'd8, 4'd9, 4'd10:   return "R6";
            4'd11, 4'd12, 4'd13: return "R8";
            4'd14:               return "R9";
            default:             return "R10";
        endcase
    endfunction

    task automatic check(input string rq, input logic [31:0] gr, input logic [31:0] er,
                         input logic gf, input logic ef, input logic gv, input logic ev);
        n_chk++;
        if (gr !== er || gf !== ef || gv !== ev) begin
            n_fail++;
            $display("FAIL %s: res=%h flag=%b vld=%b, expected res=%h flag=%b vld=%b",
                     rq, gr, gf, gv, er, ef, ev);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [4:0] sh, input logic p,
                         input logic [31:0] a, input logic [31:0] b);
        op_i = op; shamt_i = sh; pred_i = p; a_i = a; b_i = b;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1", res_o, 32'h0, flag_o, 1'b0, vld_o, 1'b0);
        rst = 1'b0;

        // Vector table, one issue per cycle
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].sh, VEC[i].p, VEC[i].a, VEC[i].b);
            @(posedge clk);
            #1;
            check(req_of(VEC[i].op), res_o, VEC[i].eres, flag_o, VEC[i].eflag,
                  vld_o, VEC[i].evld);
        end

        // R7: predicate high on a non-compare op leaves the flag low after a true compare
        drive(4'd8, 5'd0, 1'b1, 32'h5, 32'h5);
        @(posedge clk); #1;
        check("R6", res_o, 32'h0, flag_o, 1'b1, vld_o, 1'b1);
        drive(4'd1, 5'd0, 1'b1, 32'h5, 32'h5);
        @(posedge clk); #1;
        check("R7", res_o, 32'hA, flag_o, 1'b0, vld_o, 1'b1);

        // R2: outputs hold the previous result until the next edge
        drive(4'd6, 5'd0, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF);
        #3;
        check("R2", res_o, 32'hA, flag_o, 1'b0, vld_o, 1'b1);
        @(posedge clk); #1;
        check("R2", res_o, 32'hFFFF_FFFF, flag_o, 1'b0, vld_o, 1'b1);

        // R10 then R2: valid drops for one silent issue and comes back
        drive(4'd15, 5'd0, 1'b0, 32'h1, 32'h1);
        @(posedge clk); #1;
        check("R10", res_o, 32'h0, flag_o, 1'b0, vld_o, 1'b0);
        drive(4'd2, 5'd0, 1'b0, 32'h0, 32'h1);
        @(posedge clk); #1;
        check("R2", res_o, 32'hFFFF_FFFF, flag_o, 1'b0, vld_o, 1'b1);

        // R1: reset in mid-stream clears a pending compare
        drive(4'd10, 5'd0, 1'b0, 32'h0, 32'h1);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1", res_o, 32'h0, flag_o, 1'b0, vld_o, 1'b0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R6", res_o, 32'h0, flag_o, 1'b1, vld_o, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule